// File: doc/BRIEF.md
# Link M/N Ratio Calculator

This block turns a video timing setup into the two clock-regeneration ratios a display link transmitter needs. From the pixel clock, the link symbol clock, the active lane count and a fixed bytes-per-pixel figure, it forms a data ratio (pixel bandwidth over link bandwidth) and a link ratio (pixel clock over link clock). Each ratio is then brought into a 24-bit register range by shifting its numerator and denominator right together, one position per cycle, until both fit. No GCD is taken: the result keeps the ratio up to truncation.

A request is a single transfer on a valid/ready input port; the block accepts one request at a time and drops `in_ready` until the result is taken. The result is offered on a valid/ready output port: once `res_valid` rises, every result output holds its value until `res_ready` is seen high at a clock edge, so a slow consumer may stall for any number of cycles. Besides the four reduced values, the block emits a packed data-M word with the transfer-unit size field, ready for a register write.

Top module: `link_mn_calc`

## Requirements
- R1: Before reduction the data numerator equals pixel clock times BPP (default 3).
- R2: Before reduction the data denominator equals link clock times lane count.
- R3: Before reduction the link numerator equals the pixel clock and the link denominator equals the link clock; every reported value is at most 0xFFFFFF.
- R4: Each pair is reduced on its own: while either member exceeds 0xFFFFFF, both members shift right by one per cycle; the result is the raw pair divided by 2^k with the smallest such k.
- R5: The packed data-M word holds the reduced data numerator in bits [23:0], the transfer-unit size minus one (63 for the default size of 64) in bits [30:25], and zero in bits 24 and 31.
- R6: A pair that already fits is reported unchanged and costs no cycles; when both pairs fit, `res_valid` is high in the cycle right after the accepting edge.
- R7: `res_valid` rises exactly k cycles after the one following the accepting edge, k being the larger of the two pairs' shift counts.
- R8: `in_ready` is high only while no request is in progress; `in_valid` and input values presented while busy are ignored.
- R9: While `res_valid` is high and `res_ready` low, `res_valid` and all result outputs stay unchanged; a result taken with `res_ready` high returns the block to idle in the next cycle.
- R10: After reset `in_ready` is high and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request accepted on this edge |
| pix_khz | input | 32 | Pixel clock in kHz |
| link_khz | input | 32 | Link symbol clock in kHz |
| lanes | input | 3 | Active lane count |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| data_m | output | 24 | Reduced data numerator |
| data_n | output | 24 | Reduced data denominator |
| link_m | output | 24 | Reduced link numerator |
| link_n | output | 24 | Reduced link denominator |
| data_m_word | output | 32 | Packed data-M register word |

## Verification
The bench builds the block with its default parameters: 32-bit inputs, 40-bit products, a 24-bit limit, three bytes per pixel and a transfer unit of 64. With those values the all-ones inputs drive the data pair to its deepest reduction of ten shifts while the link pair needs eight, so the latency rule for unequal counts is exercised, as are the exact 0xFFFFFF boundary, a one-over-boundary case and a case where the denominator alone forces the shifting.

// File: rtl/mn_pkg.sv
package mn_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mn_state_e;

  localparam int PAIR_DATA = 0;
  localparam int PAIR_LINK = 1;
  localparam int NPAIR     = 2;
endpackage

// File: rtl/mn_terms.sv
module mn_terms #(
  parameter int IN_W   = 32,
  parameter int LANE_W = 3,
  parameter int PW     = 40,
  parameter int BPP    = 3
) (
  input  logic [IN_W-1:0]   pix_i,
  input  logic [IN_W-1:0]   link_i,
  input  logic [LANE_W-1:0] lanes_i,
  output logic [PW-1:0]     dat_num_o,
  output logic [PW-1:0]     dat_den_o,
  output logic [PW-1:0]     lnk_num_o,
  output logic [PW-1:0]     lnk_den_o
);
  localparam logic [PW-1:0] BPP_W = PW'(BPP);

  always_comb begin
    dat_num_o = PW'(pix_i) * BPP_W;
    dat_den_o = PW'(link_i) * PW'(lanes_i);
    lnk_num_o = PW'(pix_i);
    lnk_den_o = PW'(link_i);
  end
endmodule

// File: rtl/mn_reduce.sv
module mn_reduce #(
  parameter int PW = 40,
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [PW-1:0] num_i,
  input  logic [PW-1:0] den_i,
  output logic [PW-1:0] num_o,
  output logic [PW-1:0] den_o,
  output logic          fit_o
);
  logic [PW-1:0] num_q, den_q;

  assign fit_o = ~|num_q[PW-1:LW] && ~|den_q[PW-1:LW];
  assign num_o = num_q;
  assign den_o = den_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q <= '0;
      den_q <= '0;
    end else if (load_i) begin
      num_q <= num_i;
      den_q <= den_i;
    end else if (!fit_o) begin
      num_q <= num_q >> 1;
      den_q <= den_q >> 1;
    end
  end
endmodule

// File: rtl/link_mn_calc.sv
module link_mn_calc
  import mn_pkg::*;
#(
  parameter int IN_W    = 32,
  parameter int LANE_W  = 3,
  parameter int PW      = 40,
  parameter int LW      = 24,
  parameter int BPP     = 3,
  parameter int TU_SIZE = 64,
  parameter int TU_POS  = 25,
  parameter int TU_W    = 6,
  parameter int WORD_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   pix_khz,
  input  logic [IN_W-1:0]   link_khz,
  input  logic [LANE_W-1:0] lanes,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [LW-1:0]     data_m,
  output logic [LW-1:0]     data_n,
  output logic [LW-1:0]     link_m,
  output logic [LW-1:0]     link_n,
  output logic [WORD_W-1:0] data_m_word
);
  localparam logic [TU_W-1:0] TU_FIELD = TU_W'(TU_SIZE - 1);

  mn_state_e        state_q;
  logic             accept;
  logic [PW-1:0]    raw_num [NPAIR];
  logic [PW-1:0]    raw_den [NPAIR];
  logic [PW-1:0]    num_q   [NPAIR];
  logic [PW-1:0]    den_q   [NPAIR];
  logic [NPAIR-1:0] fit;

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign res_valid = (state_q == ST_RUN) && (&fit);

  mn_terms #(.IN_W(IN_W), .LANE_W(LANE_W), .PW(PW), .BPP(BPP)) u_terms (
    .pix_i     (pix_khz),
    .link_i    (link_khz),
    .lanes_i   (lanes),
    .dat_num_o (raw_num[PAIR_DATA]),
    .dat_den_o (raw_den[PAIR_DATA]),
    .lnk_num_o (raw_num[PAIR_LINK]),
    .lnk_den_o (raw_den[PAIR_LINK])
  );

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    mn_reduce #(.PW(PW), .LW(LW)) u_red (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .num_i  (raw_num[g]),
      .den_i  (raw_den[g]),
      .num_o  (num_q[g]),
      .den_o  (den_q[g]),
      .fit_o  (fit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) state_q <= ST_RUN;
        ST_RUN:  if (res_valid && res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_m = num_q[PAIR_DATA][LW-1:0];
  assign data_n = den_q[PAIR_DATA][LW-1:0];
  assign link_m = num_q[PAIR_LINK][LW-1:0];
  assign link_n = den_q[PAIR_LINK][LW-1:0];

  always_comb begin
    data_m_word                   = '0;
    data_m_word[LW-1:0]           = data_m;
    data_m_word[TU_POS +: TU_W]   = TU_FIELD;
  end
endmodule

// File: rtl/mn_ratio_chk.sv
module mn_ratio_chk #(
  parameter int PW      = 40,
  parameter int LW      = 24,
  parameter int TU_SIZE = 64,
  parameter int TU_POS  = 25,
  parameter int TU_W    = 6,
  parameter int WORD_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              in_valid,
  input logic              res_valid,
  input logic              res_ready,
  input logic [LW-1:0]     data_m,
  input logic [LW-1:0]     data_n,
  input logic [LW-1:0]     link_m,
  input logic [LW-1:0]     link_n,
  input logic [WORD_W-1:0] m_word,
  input logic [PW-1:0]     dat_num,
  input logic [PW-1:0]     dat_den,
  input logic [PW-1:0]     lnk_num,
  input logic [PW-1:0]     lnk_den
);
  logic accept;
  logic dat_over;
  assign accept   = in_valid && in_ready;
  assign dat_over = |dat_num[PW-1:LW] || |dat_den[PW-1:LW];

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (dat_num[PW-1:LW] == '0 && dat_den[PW-1:LW] == '0 &&
                   lnk_num[PW-1:LW] == '0 && lnk_den[PW-1:LW] == '0));

  p_halve_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_over && !accept) |=> (dat_num == ($past(dat_num) >> 1) &&
                               dat_den == ($past(dat_den) >> 1)));

  p_tu_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (m_word[TU_POS +: TU_W] == TU_W'(TU_SIZE - 1) &&
                   m_word[LW-1:0] == data_m));

  p_busy_no_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(data_m) && $stable(data_n)
                                   && $stable(link_m) && $stable(link_n)));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (in_ready && !res_valid));
endmodule

bind link_mn_calc mn_ratio_chk #(
  .PW(PW), .LW(LW), .TU_SIZE(TU_SIZE), .TU_POS(TU_POS), .TU_W(TU_W), .WORD_W(WORD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .in_valid  (in_valid),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .data_m    (data_m),
  .data_n    (data_n),
  .link_m    (link_m),
  .link_n    (link_n),
  .m_word    (data_m_word),
  .dat_num   (num_q[0]),
  .dat_den   (den_q[0]),
  .lnk_num   (num_q[1]),
  .lnk_den   (den_q[1])
);

// File: tb/test_link_mn_calc.sv
module test_link_mn_calc;
  localparam int CLK_PERIOD = 10;
  localparam longint LIMIT = 64'hFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] pix_khz = '0;
  logic [31:0] link_khz = '0;
  logic [2:0]  lanes = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [23:0] data_m, data_n, link_m, link_n;
  logic [31:0] data_m_word;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_mn_calc i_link_mn_calc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pix_khz(pix_khz), .link_khz(link_khz), .lanes(lanes),
    .res_valid(res_valid), .res_ready(res_ready),
    .data_m(data_m), .data_n(data_n), .link_m(link_m), .link_n(link_n),
    .data_m_word(data_m_word)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // shift both members right together until both fit in 24 bits
  function automatic int reduce(inout longint n, inout longint d);
    int k = 0;
    while (n > LIMIT || d > LIMIT) begin
      n = n >> 1;
      d = d >> 1;
      k++;
    end
    return k;
  endfunction

  task automatic run_case(input string name, input longint pix, input longint lnk,
                          input int ln, input int hold, input bit poke);
    longint dm, dn, lm, lnn;
    int kd, kl, k, cycles;
    logic [23:0] sm;
    dm = pix * 3;          // R1
    dn = lnk * ln;         // R2
    lm = pix;              // R3
    lnn = lnk;
    kd = reduce(dm, dn);   // R4
    kl = reduce(lm, lnn);
    k = (kd > kl) ? kd : kl;
    @(negedge clk);
    check({name, " R8 idle ready"}, longint'(in_ready), 1);
    pix_khz = pix[31:0];
    link_khz = lnk[31:0];
    lanes = ln[2:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cycles = 0;
    while (!res_valid && cycles < 64) begin
      if (poke) begin
        check({name, " R8 busy not ready"}, longint'(in_ready), 0);
        in_valid = 1'b1;
        pix_khz = 32'd7;
        link_khz = 32'd11;
        lanes = 3'd1;
      end
      cycles++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check({name, " R7 R6 latency"}, cycles, k);
    check({name, " R1 R4 data_m"}, longint'(data_m), dm);
    check({name, " R2 R4 data_n"}, longint'(data_n), dn);
    check({name, " R3 R4 link_m"}, longint'(link_m), lm);
    check({name, " R3 R4 link_n"}, longint'(link_n), lnn);
    check({name, " R5 word"}, longint'(data_m_word), longint'({1'b0, 6'd63, 1'b0, dm[23:0]}));
    sm = data_m;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check({name, " R9 hold valid"}, longint'(res_valid), 1);
      check({name, " R9 hold data_m"}, longint'(data_m), longint'(sm));
      check({name, " R9 hold link_n"}, longint'(link_n), lnn);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check({name, " R9 released"}, longint'(res_valid), 0);
    check({name, " R8 ready again"}, longint'(in_ready), 1);
  endtask

  task automatic t_typical();     run_case("typical", 148500, 270000, 4, 0, 0); endtask
  task automatic t_exact_fit();   run_case("exact_fit", 64'h555555, 64'hFFFFFF, 1, 0, 0); endtask
  task automatic t_one_over();    run_case("one_over", 64'h555556, 162000, 2, 0, 0); endtask
  task automatic t_big_pix();     run_case("big_pix", 64'h1000000, 270000, 1, 0, 0); endtask
  task automatic t_den_heavy();   run_case("den_heavy", 1000, 64'h80000000, 2, 0, 0); endtask
  task automatic t_all_ones();    run_case("all_ones", 64'hFFFFFFFF, 64'hFFFFFFFF, 4, 0, 1); endtask
  task automatic t_backpressure(); run_case("backpressure", 64'h2000000, 540000, 4, 4, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset in_ready", longint'(in_ready), 1);
    check("R10 reset res_valid", longint'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset res_valid", longint'(res_valid), 0);
    t_typical();
    t_exact_fit();
    t_one_over();
    t_big_pix();
    t_den_heavy();
    t_all_ones();
    t_backpressure();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule